// File: doc/BRIEF.md
# Multichannel SPI Interrupt Status Register

This block holds the interrupt status flags of a four-channel SPI controller. Each flag is sticky. It is set by a one-cycle event from the channel logic, or in one case by a channel being switched on. It stays set until software writes a 1 to its position. Each channel has three flags: transmit empty, transmit underflow and receive full. Channel 0 has a fourth flag for receive overflow. Two flags are shared by all channels: a wake-up flag for target mode and an end-of-word-count flag.

A second register of the same width holds an interrupt enable mask. The interrupt line is driven high when any status bit is set together with its mask bit. Software reaches both registers through a plain write port and a registered read port. The SPI shifter, the FIFOs and the DMA are not part of the block. Their activity arrives only as event pulses, per-channel enable levels and data-load strobes.

Top module: `spi_int_status`

## Requirements
- R1: Channel n owns bits 4n to 4n+3 of the status word. Bit 4n is transmit empty, bit 4n+1 is transmit underflow and bit 4n+2 is receive full. Bit 3 is the channel 0 receive-overflow flag, bit 16 is wake-up and bit 17 is end-of-word-count. With rd_sel=0 the read port returns the status word and with rd_sel=1 it returns the mask. rd_data shows the selected register as it stood before the clock edge that loads rd_data.
- R2: Bits 31:18, 15, 11 and 7 of both registers always read as 0, and writes to these bits have no effect.
- R3: Under reset, every status and mask bit clears to 0, and so do rd_data and irq.
- R4: A status write (wr_en=1, wr_sel=0) clears every status bit whose wr_data bit is 1 and leaves every bit whose wr_data bit is 0 unchanged. A mask write (wr_en=1, wr_sel=1) stores wr_data into the mask.
- R5: A rising edge of chan_en[n] sets the transmit-empty flag of channel n, with no event pulse needed.
- R6: The transmit-underflow flag of channel n is not set unless data_load[n] has been pulsed in an earlier cycle since chan_en[n] last went high.
- R7: The transmit-empty, transmit-underflow and receive-full event pulses of channel n set their flags only while chan_en[n] is 1.
- R8: The receive-overflow flag is set only when ev_rx0_ovf, chan_en[0] and target_mode are all 1.
- R9: The wake-up flag is set when cs_active goes from 0 to 1 while target_mode is 1.
- R10: The end-of-word-count flag is set when wcnt_done is pulsed while fifo_mode is 1.
- R11: If a set event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R12: irq is registered. After each edge it equals the OR over all bits of (status AND mask), taken as they stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chan_en | input | 4 | Per-channel enable level |
| data_load | input | 4 | Per-channel transmit data-load strobe |
| ev_tx_empty | input | 4 | Transmit-empty event pulses |
| ev_tx_udf | input | 4 | Transmit-underflow event pulses |
| ev_rx_full | input | 4 | Receive-full event pulses |
| ev_rx0_ovf | input | 1 | Channel 0 receive-overflow event pulse |
| target_mode | input | 1 | Controller is in target mode |
| cs_active | input | 1 | Selected chip-select input is active |
| fifo_mode | input | 1 | FIFO buffering is in use |
| wcnt_done | input | 1 | Programmed word count reached |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 mask |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 status, 1 mask |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is the underflow gate. An underflow pulse must be shown to be dropped when it arrives on the enable cycle and in the cycles after it, while no data load has yet been seen. The same pulse must then be accepted once a load has been made. A directed sequence runs this on channel 1: enable, underflow pulses without a load, one load, then another underflow pulse. Further directed sequences collide a clearing write with a set event on the same bit, and write all ones to both registers to expose the reserved positions. Long random runs then toggle enables, loads, mode levels and writes so that these cases also occur in mixed order.

// File: rtl/spi_int_status_pkg.sv
package spi_int_status_pkg;

  localparam int GRP_W = 4;

  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_sel_e;

  // Positions that hold a real flag, for a given channel count and width
  function automatic logic [31:0] live_bits(input int nch);
    logic [31:0] v;
    v = '0;
    for (int n = 0; n < nch; n++) begin
      v[GRP_W*n]     = 1'b1;
      v[GRP_W*n + 1] = 1'b1;
      v[GRP_W*n + 2] = 1'b1;
    end
    v[3]             = 1'b1;
    v[GRP_W*nch]     = 1'b1;
    v[GRP_W*nch + 1] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/spi_chan_flags.sv
module spi_chan_flags
  import spi_int_status_pkg::*;
#(
  parameter bit HAS_OVF = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             chan_en,
  input  logic             data_load,
  input  logic             ev_tx_empty,
  input  logic             ev_tx_udf,
  input  logic             ev_rx_full,
  input  logic             ev_rx_ovf,
  input  logic             target_mode,
  input  logic [GRP_W-1:0] clr,
  output logic [GRP_W-1:0] flags
);

  logic en_q, loaded_q;
  logic txe_q, udf_q, rxf_q;
  logic en_rise, set_txe, set_udf, set_rxf;

  assign en_rise = chan_en & ~en_q;
  assign set_txe = en_rise | (chan_en & ev_tx_empty);
  assign set_udf = chan_en & ev_tx_udf & loaded_q;
  assign set_rxf = chan_en & ev_rx_full;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q     <= 1'b0;
      loaded_q <= 1'b0;
      txe_q    <= 1'b0;
      udf_q    <= 1'b0;
      rxf_q    <= 1'b0;
    end else begin
      en_q     <= chan_en;
      loaded_q <= chan_en ? (loaded_q | data_load) : 1'b0;
      txe_q    <= set_txe | (txe_q & ~clr[0]);
      udf_q    <= set_udf | (udf_q & ~clr[1]);
      rxf_q    <= set_rxf | (rxf_q & ~clr[2]);
    end
  end

  generate
    if (HAS_OVF) begin : g_ovf
      logic ovf_q, set_ovf;
      assign set_ovf = chan_en & target_mode & ev_rx_ovf;
      always_ff @(posedge clk) begin
        if (rst) ovf_q <= 1'b0;
        else     ovf_q <= set_ovf | (ovf_q & ~clr[3]);
      end
      assign flags = {ovf_q, rxf_q, udf_q, txe_q};

      assert_ovf_gate_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(ovf_q) |-> $past(target_mode && chan_en && ev_rx_ovf));
    end else begin : g_no_ovf
      logic unused_ovf;
      assign unused_ovf = ev_rx_ovf ^ target_mode ^ clr[3];
      assign flags = {1'b0, rxf_q, udf_q, txe_q};
    end
  endgenerate

  assert_enable_sets_empty_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_en) |=> txe_q);

  assert_udf_needs_load_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(udf_q) |-> $past(loaded_q && chan_en));

  assert_rxf_only_enabled_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(rxf_q) |-> $past(chan_en));

  assert_clear_works_R4: assert property (@(posedge clk) disable iff (rst)
    (clr[2] && !set_rxf) |=> !rxf_q);

  assert_set_wins_R11: assert property (@(posedge clk) disable iff (rst)
    (set_txe && clr[0]) |=> txe_q);

endmodule

// File: rtl/spi_sys_flags.sv
module spi_sys_flags (
  input  logic       clk,
  input  logic       rst,
  input  logic       target_mode,
  input  logic       cs_active,
  input  logic       fifo_mode,
  input  logic       wcnt_done,
  input  logic [1:0] clr,
  output logic [1:0] flags
);

  logic cs_q, wake_q, eow_q, set_wake, set_eow;

  assign set_wake = target_mode & cs_active & ~cs_q;
  assign set_eow  = fifo_mode & wcnt_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_q   <= 1'b0;
      wake_q <= 1'b0;
      eow_q  <= 1'b0;
    end else begin
      cs_q   <= cs_active;
      wake_q <= set_wake | (wake_q & ~clr[0]);
      eow_q  <= set_eow  | (eow_q  & ~clr[1]);
    end
  end

  assign flags = {eow_q, wake_q};

  assert_wake_gate_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(wake_q) |-> $past(target_mode && cs_active && !cs_q));

  assert_eow_gate_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(eow_q) |-> $past(fifo_mode && wcnt_done));

endmodule

// File: rtl/spi_mask_reg.sv
module spi_mask_reg #(
  parameter int          REG_W = 32,
  parameter logic [31:0] LIVE  = 32'h0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] mask
);

  always_ff @(posedge clk) begin
    if (rst)     mask <= '0;
    else if (wr) mask <= wr_data & LIVE[REG_W-1:0];
  end

  assert_mask_resv_R2: assert property (@(posedge clk) disable iff (rst)
    wr |=> ((mask & ~LIVE[REG_W-1:0]) == '0));

endmodule

// File: rtl/spi_int_status.sv
module spi_int_status
  import spi_int_status_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] chan_en,
  input  logic [NUM_CH-1:0] data_load,
  input  logic [NUM_CH-1:0] ev_tx_empty,
  input  logic [NUM_CH-1:0] ev_tx_udf,
  input  logic [NUM_CH-1:0] ev_rx_full,
  input  logic              ev_rx0_ovf,
  input  logic              target_mode,
  input  logic              cs_active,
  input  logic              fifo_mode,
  input  logic              wcnt_done,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  input  logic              rd_sel,
  output logic [REG_W-1:0]  rd_data,
  output logic              irq
);

  localparam int          WAKE_POS = GRP_W * NUM_CH;
  localparam int          EOW_POS  = WAKE_POS + 1;
  localparam logic [31:0] LIVE     = live_bits(NUM_CH);

  logic [REG_W-1:0] status, mask, clr_vec;
  logic             stat_wr, mask_wr;

  assign stat_wr = wr_en & (reg_sel_e'(wr_sel) == REG_STATUS);
  assign mask_wr = wr_en & (reg_sel_e'(wr_sel) == REG_MASK);
  assign clr_vec = stat_wr ? wr_data : '0;

  genvar n;
  generate
    for (n = 0; n < NUM_CH; n++) begin : g_ch
      logic [GRP_W-1:0] grp;
      spi_chan_flags #(.HAS_OVF(n == 0)) u_flags (
        .clk         (clk),
        .rst         (rst),
        .chan_en     (chan_en[n]),
        .data_load   (data_load[n]),
        .ev_tx_empty (ev_tx_empty[n]),
        .ev_tx_udf   (ev_tx_udf[n]),
        .ev_rx_full  (ev_rx_full[n]),
        .ev_rx_ovf   ((n == 0) ? ev_rx0_ovf : 1'b0),
        .target_mode (target_mode),
        .clr         (clr_vec[GRP_W*n +: GRP_W]),
        .flags       (grp)
      );
      assign status[GRP_W*n +: GRP_W] = grp;
    end
    if (REG_W > EOW_POS + 1) begin : g_pad
      assign status[REG_W-1:EOW_POS+1] = '0;
    end
  endgenerate

  spi_sys_flags u_sys (
    .clk         (clk),
    .rst         (rst),
    .target_mode (target_mode),
    .cs_active   (cs_active),
    .fifo_mode   (fifo_mode),
    .wcnt_done   (wcnt_done),
    .clr         (clr_vec[EOW_POS:WAKE_POS]),
    .flags       (status[EOW_POS:WAKE_POS])
  );

  spi_mask_reg #(.REG_W(REG_W), .LIVE(LIVE)) u_mask (
    .clk     (clk),
    .rst     (rst),
    .wr      (mask_wr),
    .wr_data (wr_data),
    .mask    (mask)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= (reg_sel_e'(rd_sel) == REG_MASK) ? mask : status;
      irq     <= |(status & mask);
    end
  end

  assert_rd_resv_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~LIVE[REG_W-1:0]) == '0);

  assert_irq_follows_R12: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|(status & mask)));

  assert_read_mux_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rd_sel) |-> rd_data == $past(mask));

endmodule

// File: tb/spi_int_status_test.sv
module spi_int_status_test;

  localparam int NCH = 4;
  localparam logic [31:0] LIVE = 32'h0003_777F;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] chan_en, data_load, ev_tx_empty, ev_tx_udf, ev_rx_full;
  logic ev_rx0_ovf, target_mode, cs_active, fifo_mode, wcnt_done;
  logic wr_en, wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic irq;

  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  spi_int_status uut (
    .clk(clk), .rst(rst), .chan_en(chan_en), .data_load(data_load),
    .ev_tx_empty(ev_tx_empty), .ev_tx_udf(ev_tx_udf), .ev_rx_full(ev_rx_full),
    .ev_rx0_ovf(ev_rx0_ovf), .target_mode(target_mode), .cs_active(cs_active),
    .fifo_mode(fifo_mode), .wcnt_done(wcnt_done), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
  );

  // Reference model built from the requirements
  logic [31:0] m_stat, m_mask, exp_rd;
  logic [NCH-1:0] m_en, m_loaded;
  logic m_cs, exp_irq, exp_sel, m_rst_seen;

  always @(posedge clk) begin
    logic [31:0] setv, clrv;
    if (rst) begin
      m_stat = '0; m_mask = '0; m_en = '0; m_loaded = '0; m_cs = 1'b0;
      exp_rd = '0; exp_irq = 1'b0; exp_sel = 1'b0; m_rst_seen = 1'b1;
    end else begin
      exp_rd  = rd_sel ? m_mask : m_stat;
      exp_sel = rd_sel;
      exp_irq = |(m_stat & m_mask);
      setv = '0;
      for (int n = 0; n < NCH; n++) begin
        setv[4*n]   = (chan_en[n] & ~m_en[n]) | (chan_en[n] & ev_tx_empty[n]);
        setv[4*n+1] = chan_en[n] & ev_tx_udf[n] & m_loaded[n];
        setv[4*n+2] = chan_en[n] & ev_rx_full[n];
      end
      setv[3]  = ev_rx0_ovf & chan_en[0] & target_mode;
      setv[16] = target_mode & cs_active & ~m_cs;
      setv[17] = fifo_mode & wcnt_done;
      clrv = (wr_en && !wr_sel) ? wr_data : '0;
      m_stat = ((m_stat & ~clrv) | setv) & LIVE;
      if (wr_en && wr_sel) m_mask = wr_data & LIVE;
      for (int n = 0; n < NCH; n++)
        m_loaded[n] = chan_en[n] ? (m_loaded[n] | data_load[n]) : 1'b0;
      m_en = chan_en;
      m_cs = cs_active;
    end
  end

  function automatic string tag_of(input int b, input logic sel);
    if (!LIVE[b]) return "R2";
    if (sel)      return "R4";
    if (b == 16)  return "R9";
    if (b == 17)  return "R10";
    if (b == 3)   return "R8";
    case (b % 4)
      0: return "R5";
      1: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic compare();
    checks++;
    if (rd_data !== exp_rd) begin
      int fb;
      fb = 0;
      for (int b = 31; b >= 0; b--) if (rd_data[b] !== exp_rd[b]) fb = b;
      fails++;
      $display("FAIL %s/R1 bit %0d: rd_data actual %h expected %h", tag_of(fb, exp_sel), fb,
               rd_data, exp_rd);
    end
    checks++;
    if (irq !== exp_irq) begin
      fails++;
      $display("FAIL R12: irq actual %b expected %b", irq, exp_irq);
    end
  endtask

  task automatic idle();
    data_load = '0; ev_tx_empty = '0; ev_tx_udf = '0; ev_rx_full = '0;
    ev_rx0_ovf = 0; wcnt_done = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
  endtask

  task automatic step();
    @(negedge clk);
    compare();
  endtask

  initial begin
    void'($urandom(32'd1357));
    rst = 1; chan_en = '0; target_mode = 0; cs_active = 0; fifo_mode = 0; rd_sel = 0;
    idle();
    repeat (3) @(negedge clk);
    // R3: values under reset
    checks++;
    if (rd_data !== 32'h0 || irq !== 1'b0) begin
      fails++;
      $display("FAIL R3: rd_data/irq actual %h/%b expected 0/0", rd_data, irq);
    end
    rst = 0;
    step();

    // R2: all ones into the mask, then read it back
    wr_en = 1; wr_sel = 1; wr_data = '1; rd_sel = 1;
    step(); idle(); step(); step();
    rd_sel = 0;

    // R6: underflow dropped before any load, accepted after one
    chan_en[1] = 1; ev_tx_udf[1] = 1; step();
    ev_tx_udf[1] = 1; step();
    ev_tx_udf[1] = 0; data_load[1] = 1; step();
    data_load[1] = 0; ev_tx_udf[1] = 1; step();
    idle(); step(); step();

    // R11: clear and set on channel 1 transmit empty in the same cycle
    ev_tx_empty[1] = 1; wr_en = 1; wr_sel = 0; wr_data = 32'h0000_0010; step();
    idle(); step(); step();
    // R4: clear all status
    wr_en = 1; wr_sel = 0; wr_data = '1; step(); idle(); step(); step();

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      for (int n = 0; n < NCH; n++) begin
        if ($urandom_range(0, 39) == 0) chan_en[n] = ~chan_en[n];
        data_load[n]   = ($urandom_range(0, 7) == 0);
        ev_tx_empty[n] = ($urandom_range(0, 9) == 0);
        ev_tx_udf[n]   = ($urandom_range(0, 5) == 0);
        ev_rx_full[n]  = ($urandom_range(0, 9) == 0);
      end
      ev_rx0_ovf = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 49) == 0) target_mode = ~target_mode;
      if ($urandom_range(0, 49) == 0) fifo_mode = ~fifo_mode;
      if ($urandom_range(0, 5) == 0) cs_active = ~cs_active;
      wcnt_done = ($urandom_range(0, 11) == 0);
      wr_en   = ($urandom_range(0, 5) == 0);
      wr_sel  = $urandom_range(0, 1);
      wr_data = ($urandom_range(0, 3) == 0) ? '1 : $urandom;
      rd_sel  = $urandom_range(0, 1);
      step();
    end
    idle(); step();

    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    #(20 * 100000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule